// File: doc/BRIEF.md
# Memory-Module Presence-Detect Fetch and Decode Sequencer

This block runs once after reset and finds out how the attached memory module is built. It controls the request side of an existing byte-register I2C read engine through five signals: a one-cycle request strobe, a busy flag, a NACK flag, the read data byte, and the device and register addresses. The block does not drive the serial wires itself.

It first looks for the presence-detect device. It probes every 7-bit bus address from zero upward, reading register 0 at each one, until a device acknowledges. It then reads nine descriptor bytes from that device: the device type, the module type, density, addressing, organisation, bus width, the two timebase bytes and the minimum clock period. It decodes each byte into fields. The minimum clock period is converted into picoseconds with a shift-and-add multiplier. A one-cycle done pulse marks the end of the sequence. A valid level then stays high, and all decoded outputs keep their values until reset. An error flag reports three things: a wrong device type, an unusable timebase divisor, or a failed access.

Top module: `spd_cfg_fetch`

## Requirements
- R1: Discovery starts at bus address 0 and reads register 0 there. Each NACK moves the probe address up by exactly one and the probe repeats. The first acknowledged address ends discovery and is held on dev_addr_o.
- R2: req_o is high for exactly one cycle per access and rises only after a cycle in which busy_i was low. The next access is launched only after busy_i has dropped again. rd_o is 1 and div_o is 249 whenever req_o is high.
- R3: After discovery, exactly nine reads go to the found address, at registers 2, 3, 4, 5, 7, 8, 10, 11 and 12, in that order.
- R4: A device-type byte (register 2) other than 0x0B sets err_o. The sequence still completes with done and valid, and err_o stays set until reset.
- R5: bank_code_o is register 4 bits [6:4] and cap_code_o is register 4 bits [3:0]. row_code_o is register 5 bits [5:3] and col_code_o is register 5 bits [2:0]. dev_type_o and mod_type_o are registers 2 and 3 unchanged.
- R6: rank_code_o is register 7 bits [5:3], width_code_o is register 7 bits [2:0], and bus_code_o is register 8 bits [2:0].
- R7: mtb_dvd_o and mtb_div_o are registers 10 and 11 unchanged.
- R8: tck_ps_o depends on the divisor in register 11. For 0x08 it is register 12 times 125. For 0x10 it is register 12 times 125, divided by 2 and rounded down. Any other divisor sets err_o and tck_ps_o is 0.
- R9: A NACK during any of the nine descriptor reads sets err_o and stops the sequence. No further request is made, and done_o and valid_o stay low.
- R10: If address 0x7F also NACKs, discovery stops with err_o set, dev_addr_o at 0x7F, no further request, and no done pulse.
- R11: done_o is a single-cycle pulse that comes once, together with the rise of valid_o, after register 12 has been decoded. Afterwards valid_o and every decoded output hold until reset.
- R12: While reset is held, req_o, done_o, valid_o, err_o, dev_addr_o and tck_ps_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_i | input | 1 | Read engine is working on an access |
| nack_i | input | 1 | Last finished access was not acknowledged |
| rdata_i | input | 8 | Byte returned by the last finished access |
| req_o | output | 1 | One-cycle access request strobe |
| rd_o | output | 1 | Access direction, always read (1) |
| dev_addr_o | output | 7 | Probe address, then the found device address |
| reg_addr_o | output | 8 | Register index of the access |
| div_o | output | 16 | Serial clock divider for the read engine |
| done_o | output | 1 | Decode complete, single-cycle pulse |
| valid_o | output | 1 | Decoded outputs are final |
| err_o | output | 1 | Wrong type, bad divisor, or failed access |
| dev_type_o | output | 8 | Device type byte |
| mod_type_o | output | 8 | Module type byte |
| bank_code_o | output | 3 | Bank address bit code |
| cap_code_o | output | 4 | Die capacity code |
| row_code_o | output | 3 | Row address bit code |
| col_code_o | output | 3 | Column address bit code |
| rank_code_o | output | 3 | Rank count code |
| width_code_o | output | 3 | Device width code |
| bus_code_o | output | 3 | Module bus width code |
| mtb_dvd_o | output | 8 | Timebase dividend byte |
| mtb_div_o | output | 8 | Timebase divisor byte |
| tck_ps_o | output | 16 | Minimum clock period in picoseconds |

## Verification
req_o rises on the first clock edge at which the sequencer wants an access and busy_i is low. It falls on the very next edge. An access finishes on the first edge at which busy_i is low after the strobe. On that same edge the byte is captured, and for the last byte, tck_ps_o, err_o, done_o and valid_o all change, so they are due one cycle after busy_i drops. The bench's responder answers at falling edges with a random latency. It logs every strobe it sees, together with the address and register of that strobe, and checks the handshake at each strobe. Decoded values, logs and the hold behaviour are checked at falling edges once valid_o is high, or once the bus has stayed quiet for 200 cycles.

// File: rtl/spd_seq_pkg.sv
package spd_seq_pkg;

  typedef enum logic [1:0] {
    ST_PROBE,
    ST_READ,
    ST_DONE,
    ST_HALT
  } seq_st_e;

  localparam int unsigned N_STEPS = 9;
  localparam int unsigned STEP_W  = $clog2(N_STEPS);

  // step index of each descriptor byte
  localparam logic [STEP_W-1:0] S_TYPE  = STEP_W'(0);
  localparam logic [STEP_W-1:0] S_MOD   = STEP_W'(1);
  localparam logic [STEP_W-1:0] S_DENS  = STEP_W'(2);
  localparam logic [STEP_W-1:0] S_ADDR  = STEP_W'(3);
  localparam logic [STEP_W-1:0] S_ORG   = STEP_W'(4);
  localparam logic [STEP_W-1:0] S_BUS   = STEP_W'(5);
  localparam logic [STEP_W-1:0] S_DVD   = STEP_W'(6);
  localparam logic [STEP_W-1:0] S_DIV   = STEP_W'(7);
  localparam logic [STEP_W-1:0] S_TCK   = STEP_W'(8);

  localparam logic [7:0] DDR3_TYPE   = 8'h0B;
  localparam logic [7:0] MTB_DIV_FULL = 8'h08;
  localparam logic [7:0] MTB_DIV_HALF = 8'h10;

  function automatic logic [7:0] step_reg(input logic [STEP_W-1:0] s);
    case (s)
      S_TYPE:  step_reg = 8'd2;
      S_MOD:   step_reg = 8'd3;
      S_DENS:  step_reg = 8'd4;
      S_ADDR:  step_reg = 8'd5;
      S_ORG:   step_reg = 8'd7;
      S_BUS:   step_reg = 8'd8;
      S_DVD:   step_reg = 8'd10;
      S_DIV:   step_reg = 8'd11;
      default: step_reg = 8'd12;
    endcase
  endfunction

endpackage

// File: rtl/spd_req_port.sv
module spd_req_port (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic busy_i,
  output logic req_o,
  output logic cpl_o
);

  logic inflight_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o      <= 1'b0;
      inflight_q <= 1'b0;
    end else if (req_o) begin
      req_o <= 1'b0;
    end else if (inflight_q) begin
      if (!busy_i) inflight_q <= 1'b0;
    end else if (fire_i && !busy_i) begin
      req_o      <= 1'b1;
      inflight_q <= 1'b1;
    end
  end

  // engine has dropped busy after our strobe
  assign cpl_o = inflight_q && !req_o && !busy_i;

endmodule

// File: rtl/spd_seq_ctl.sv
module spd_seq_ctl
  import spd_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned REG_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpl_i,
  input  logic              nack_i,
  output logic              fire_o,
  output logic [ADDR_W-1:0] dev_addr_o,
  output logic [REG_W-1:0]  reg_addr_o,
  output logic              cap_o,
  output logic [STEP_W-1:0] step_o,
  output logic              done_o,
  output logic              fin_o,
  output logic              fail_o
);

  localparam logic [ADDR_W-1:0] ADDR_LAST = '1;
  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(N_STEPS - 1);

  seq_st_e           st_q;
  logic [ADDR_W-1:0] addr_q;
  logic [STEP_W-1:0] step_q;
  logic              done_q;
  logic              fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_PROBE;
      addr_q <= '0;
      step_q <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_PROBE: if (cpl_i) begin
          if (!nack_i) begin
            st_q   <= ST_READ;
            step_q <= '0;
          end else if (addr_q == ADDR_LAST) begin
            st_q   <= ST_HALT;
            fail_q <= 1'b1;
          end else begin
            addr_q <= addr_q + 1'b1;
          end
        end
        ST_READ: if (cpl_i) begin
          if (nack_i) begin
            st_q   <= ST_HALT;
            fail_q <= 1'b1;
          end else if (step_q == STEP_LAST) begin
            st_q   <= ST_DONE;
            done_q <= 1'b1;
          end else begin
            step_q <= step_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign fire_o     = (st_q == ST_PROBE) || (st_q == ST_READ);
  assign dev_addr_o = addr_q;
  assign reg_addr_o = (st_q == ST_PROBE) ? '0 : REG_W'(step_reg(step_q));
  assign cap_o      = cpl_i && !nack_i && (st_q == ST_READ);
  assign step_o     = step_q;
  assign done_o     = done_q;
  assign fin_o      = (st_q == ST_DONE);
  assign fail_o     = fail_q;

endmodule

// File: rtl/spd_field_dec.sv
module spd_field_dec
  import spd_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TCK_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [7:0]        dev_type_o,
  output logic [7:0]        mod_type_o,
  output logic [7:0]        dens_o,
  output logic [7:0]        addr_o,
  output logic [7:0]        org_o,
  output logic [7:0]        bus_o,
  output logic [7:0]        mtb_dvd_o,
  output logic [7:0]        mtb_div_o,
  output logic [TCK_W-1:0]  tck_ps_o,
  output logic              bad_o
);

  logic [7:0]       byte_in;
  logic [TCK_W-1:0] b_ext, x125, tck_next;
  logic             div_full, div_half;
  logic             bad_type_q, bad_div_q;

  assign byte_in = rdata_i[7:0];

  // x*125 = x*128 - x*4 + x
  assign b_ext    = TCK_W'(byte_in);
  assign x125     = (b_ext << 7) - (b_ext << 2) + b_ext;
  assign div_full = (mtb_div_o == MTB_DIV_FULL);
  assign div_half = (mtb_div_o == MTB_DIV_HALF);
  assign tck_next = div_full ? x125 : (div_half ? (x125 >> 1) : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dev_type_o <= '0;
      mod_type_o <= '0;
      dens_o     <= '0;
      addr_o     <= '0;
      org_o      <= '0;
      bus_o      <= '0;
      mtb_dvd_o  <= '0;
      mtb_div_o  <= '0;
      tck_ps_o   <= '0;
      bad_type_q <= 1'b0;
      bad_div_q  <= 1'b0;
    end else if (cap_i) begin
      case (step_i)
        S_TYPE: begin
          dev_type_o <= byte_in;
          bad_type_q <= (byte_in != DDR3_TYPE);
        end
        S_MOD:  mod_type_o <= byte_in;
        S_DENS: dens_o     <= byte_in;
        S_ADDR: addr_o     <= byte_in;
        S_ORG:  org_o      <= byte_in;
        S_BUS:  bus_o      <= byte_in;
        S_DVD:  mtb_dvd_o  <= byte_in;
        S_DIV:  mtb_div_o  <= byte_in;
        S_TCK: begin
          tck_ps_o  <= tck_next;
          bad_div_q <= !(div_full || div_half);
        end
        default: ;
      endcase
    end
  end

  assign bad_o = bad_type_q || bad_div_q;

endmodule

// File: rtl/spd_cfg_fetch.sv
module spd_cfg_fetch
  import spd_seq_pkg::*;
#(
  parameter int unsigned ADDR_W  = 7,
  parameter int unsigned REG_W   = 8,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned TCK_W   = 16,
  parameter int unsigned CLK_DIV = 249
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              nack_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              req_o,
  output logic              rd_o,
  output logic [ADDR_W-1:0] dev_addr_o,
  output logic [REG_W-1:0]  reg_addr_o,
  output logic [DIV_W-1:0]  div_o,
  output logic              done_o,
  output logic              valid_o,
  output logic              err_o,
  output logic [7:0]        dev_type_o,
  output logic [7:0]        mod_type_o,
  output logic [2:0]        bank_code_o,
  output logic [3:0]        cap_code_o,
  output logic [2:0]        row_code_o,
  output logic [2:0]        col_code_o,
  output logic [2:0]        rank_code_o,
  output logic [2:0]        width_code_o,
  output logic [2:0]        bus_code_o,
  output logic [7:0]        mtb_dvd_o,
  output logic [7:0]        mtb_div_o,
  output logic [TCK_W-1:0]  tck_ps_o
);

  logic              fire, cpl, cap, fail, bad;
  logic [STEP_W-1:0] step;
  logic [7:0]        dens, addr_b, org, bus;

  spd_req_port i_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .busy_i (busy_i),
    .req_o  (req_o),
    .cpl_o  (cpl)
  );

  spd_seq_ctl #(
    .ADDR_W (ADDR_W),
    .REG_W  (REG_W)
  ) i_ctl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cpl_i      (cpl),
    .nack_i     (nack_i),
    .fire_o     (fire),
    .dev_addr_o (dev_addr_o),
    .reg_addr_o (reg_addr_o),
    .cap_o      (cap),
    .step_o     (step),
    .done_o     (done_o),
    .fin_o      (valid_o),
    .fail_o     (fail)
  );

  spd_field_dec #(
    .DATA_W (DATA_W),
    .TCK_W  (TCK_W)
  ) i_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (cap),
    .step_i     (step),
    .rdata_i    (rdata_i),
    .dev_type_o (dev_type_o),
    .mod_type_o (mod_type_o),
    .dens_o     (dens),
    .addr_o     (addr_b),
    .org_o      (org),
    .bus_o      (bus),
    .mtb_dvd_o  (mtb_dvd_o),
    .mtb_div_o  (mtb_div_o),
    .tck_ps_o   (tck_ps_o),
    .bad_o      (bad)
  );

  assign rd_o         = 1'b1;
  assign div_o        = DIV_W'(CLK_DIV);
  assign err_o        = fail || bad;
  assign bank_code_o  = dens[6:4];
  assign cap_code_o   = dens[3:0];
  assign row_code_o   = addr_b[5:3];
  assign col_code_o   = addr_b[2:0];
  assign rank_code_o  = org[5:3];
  assign width_code_o = org[2:0];
  assign bus_code_o   = bus[2:0];

endmodule

// File: rtl/spd_cfg_fetch_chk.sv
module spd_cfg_fetch_chk #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned TCK_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_o,
  input logic              busy_i,
  input logic              done_o,
  input logic              valid_o,
  input logic              err_o,
  input logic [ADDR_W-1:0] dev_addr_o,
  input logic [TCK_W-1:0]  tck_ps_o
);

  p_req_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);

  p_req_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_o) |-> !$past(busy_i));

  p_probe_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !$stable(dev_addr_o)) |-> ((dev_addr_o - $past(dev_addr_o)) == ADDR_W'(1)));

  p_done_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> valid_o);

  p_valid_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> (valid_o && $stable(tck_ps_o) && $stable(dev_addr_o)));

  p_err_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);

endmodule

bind spd_cfg_fetch spd_cfg_fetch_chk #(
  .ADDR_W (ADDR_W),
  .TCK_W  (TCK_W)
) i_spd_cfg_fetch_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_o      (req_o),
  .busy_i     (busy_i),
  .done_o     (done_o),
  .valid_o    (valid_o),
  .err_o      (err_o),
  .dev_addr_o (dev_addr_o),
  .tck_ps_o   (tck_ps_o)
);

// File: tb/test_spd_cfg_fetch.sv
`timescale 1ns/1ps
module test_spd_cfg_fetch;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic       busy = 1'b0, nack = 1'b0;
  logic [7:0] rdata = 8'h00;

  logic        req_o, rd_o, done_o, valid_o, err_o;
  logic [6:0]  dev_addr_o;
  logic [7:0]  reg_addr_o, dev_type_o, mod_type_o, mtb_dvd_o, mtb_div_o;
  logic [15:0] div_o, tck_ps_o;
  logic [2:0]  bank_code_o, row_code_o, col_code_o, rank_code_o, width_code_o, bus_code_o;
  logic [3:0]  cap_code_o;

  spd_cfg_fetch i_spd_cfg_fetch (
    .clk_i(clk), .rst_ni(rst_n), .busy_i(busy), .nack_i(nack), .rdata_i(rdata),
    .req_o(req_o), .rd_o(rd_o), .dev_addr_o(dev_addr_o), .reg_addr_o(reg_addr_o),
    .div_o(div_o), .done_o(done_o), .valid_o(valid_o), .err_o(err_o),
    .dev_type_o(dev_type_o), .mod_type_o(mod_type_o), .bank_code_o(bank_code_o),
    .cap_code_o(cap_code_o), .row_code_o(row_code_o), .col_code_o(col_code_o),
    .rank_code_o(rank_code_o), .width_code_o(width_code_o), .bus_code_o(bus_code_o),
    .mtb_dvd_o(mtb_dvd_o), .mtb_div_o(mtb_div_o), .tck_ps_o(tck_ps_o)
  );

  logic [7:0] img [16];
  int tgt, nack_reg, log_n, since_req, done_cnt, req_run, proto_err, cnt, cur_a, cur_r;
  int log_a [256];
  int log_r [256];
  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_tck(input int b, input int dv);
    if (dv == 8) return b * 125;
    if (dv == 16) return (b * 125) / 2;
    return 0;
  endfunction

  function automatic int read_reg(input int i);
    int tbl [9] = '{2, 3, 4, 5, 7, 8, 10, 11, 12};
    return tbl[i];
  endfunction

  // behavioural register-read engine, acting on falling edges
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        busy = 1'b0; cnt = 0; req_run = 0;
      end else if (req_o) begin
        if (busy) proto_err++;
        req_run++;
        if (req_run > 1) proto_err++;
        if (!rd_o || div_o != 16'd249) proto_err++;
        if (log_n < 256) begin
          log_a[log_n] = int'(dev_addr_o);
          log_r[log_n] = int'(reg_addr_o);
        end
        log_n++;
        cur_a = int'(dev_addr_o);
        cur_r = int'(reg_addr_o);
        busy = 1'b1;
        cnt = 1 + int'($urandom % 5);
        since_req = 0;
      end else begin
        req_run = 0;
        since_req++;
        if (busy) begin
          cnt--;
          if (cnt == 0) begin
            busy = 1'b0;
            nack = (cur_a != tgt) || (cur_r == nack_reg);
            rdata = (!nack && cur_r < 16) ? img[cur_r] : 8'hFF;
          end
        end
      end
      if (rst_n && done_o) done_cnt++;
    end
  end

  task automatic run_case(input int t, input int nr);
    rst_n = 1'b0;
    tgt = t; nack_reg = nr;
    log_n = 0; since_req = 0; done_cnt = 0; proto_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    do @(negedge clk); while (!valid_o && since_req < 200);
  endtask

  task automatic check_good(input int t);
    bit ok;
    logic [15:0] tck_snap;
    int exp_e;
    chk(done_cnt == 1, "R11 done pulses", done_cnt, 1);
    chk(valid_o == 1'b1, "R11 valid", int'(valid_o), 1);
    chk(int'(dev_addr_o) == t, "R1 found address", int'(dev_addr_o), t);
    ok = (log_n == t + 10);
    for (int i = 0; i <= t && ok; i++) ok = (log_a[i] == i) && (log_r[i] == 0);
    chk(ok, "R1 probe order", log_n, t + 10);
    ok = (log_n == t + 10);
    for (int i = 0; i < 9 && ok; i++) ok = (log_a[t+1+i] == t) && (log_r[t+1+i] == read_reg(i));
    chk(ok, "R3 read order", log_n, t + 10);
    chk(proto_err == 0, "R2 handshake", proto_err, 0);
    chk(dev_type_o == img[2] && mod_type_o == img[3], "R5 type bytes",
        int'({dev_type_o, mod_type_o}), int'({img[2], img[3]}));
    chk(bank_code_o == img[4][6:4] && cap_code_o == img[4][3:0] &&
        row_code_o == img[5][5:3] && col_code_o == img[5][2:0], "R5 density/addressing",
        int'({bank_code_o, cap_code_o, row_code_o, col_code_o}),
        int'({img[4][6:4], img[4][3:0], img[5][5:3], img[5][2:0]}));
    chk(rank_code_o == img[7][5:3] && width_code_o == img[7][2:0] && bus_code_o == img[8][2:0],
        "R6 organisation", int'({rank_code_o, width_code_o, bus_code_o}),
        int'({img[7][5:3], img[7][2:0], img[8][2:0]}));
    chk(mtb_dvd_o == img[10] && mtb_div_o == img[11], "R7 timebase",
        int'({mtb_dvd_o, mtb_div_o}), int'({img[10], img[11]}));
    chk(int'(tck_ps_o) == exp_tck(int'(img[12]), int'(img[11])), "R8 tck",
        int'(tck_ps_o), exp_tck(int'(img[12]), int'(img[11])));
    exp_e = (img[2] != 8'h0B || (img[11] != 8'h08 && img[11] != 8'h10)) ? 1 : 0;
    chk(int'(err_o) == exp_e, "R4 error flag", int'(err_o), exp_e);
    tck_snap = tck_ps_o;
    repeat (20) @(negedge clk);
    chk(valid_o && tck_ps_o == tck_snap && done_cnt == 1 && log_n == t + 10,
        "R11 hold", int'(tck_ps_o), int'(tck_snap));
  endtask

  task automatic fill_img(input int dv, input int b12, input int ty);
    for (int i = 0; i < 16; i++) img[i] = 8'($urandom);
    img[2] = 8'(ty); img[10] = 8'h01; img[11] = 8'(dv); img[12] = 8'(b12);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    tgt = 200; nack_reg = 255;
    for (int i = 0; i < 16; i++) img[i] = 8'h00;
    repeat (2) @(negedge clk);
    chk(!req_o && !done_o && !valid_o && !err_o && dev_addr_o == 7'd0 && tck_ps_o == 16'd0,
        "R12 reset state", int'({req_o, done_o, valid_o, err_o}), 0);

    fill_img(8, 15, 8'h0B);   run_case(8'h50, 255); check_good(8'h50);
    fill_img(16, 20, 8'h0B);  run_case(0, 255);     check_good(0);
    fill_img(16, 255, 8'h0B); run_case(8'h7F, 255); check_good(8'h7F);
    fill_img(8, 255, 8'h0B);  run_case(3, 255);     check_good(3);
    fill_img(8, 12, 8'h0C);   run_case(8'h51, 255); check_good(8'h51);   // R4
    fill_img(8'h20, 9, 8'h0B); run_case(2, 255);    check_good(2);       // R8 bad divisor
    chk(tck_ps_o == 16'd0 && err_o, "R8 bad divisor", int'(tck_ps_o), 0);

    for (int k = 0; k < 6; k++) begin
      fill_img(($urandom % 2) ? 16 : 8, int'($urandom % 256), 8'h0B);
      run_case(8'h50 + int'($urandom % 8), 255);
      check_good(tgt);
    end

    // R9: nack on register 7 during the read phase
    fill_img(8, 10, 8'h0B); run_case(8'h52, 7);
    chk(err_o && !valid_o && done_cnt == 0, "R9 halt on read nack", done_cnt, 0);
    chk(log_n == 8'h52 + 6 && log_r[log_n-1] == 7, "R9 no further requests", log_n, 8'h52 + 6);

    // R10: no device anywhere
    run_case(200, 255);
    chk(err_o && !valid_o && done_cnt == 0, "R10 wrap error", done_cnt, 0);
    chk(log_n == 128 && dev_addr_o == 7'h7F, "R10 probe count", log_n, 128);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule